// File: doc/BRIEF.md
# Serial Debug Memory Command Responder

This block is the target-side command engine of a serial background-debug link. A shift-register front end moves one full-duplex transfer at a time. Each transfer carries one 16-bit word from the host and one 17-bit word (a status bit plus 16 data bits) back to the host. When a transfer completes, the front end pulses `rx_valid` with the received word. The block then registers the word that the front end shifts out on the next transfer. Every response therefore trails the host word it answers by one transfer. A result transfer also carries the host's next command.

Two commands are supported: memory read and memory write, each at byte, word or long size. The block collects a two-word absolute address and, for writes, one or two immediate data words. It then runs a single access on a request/acknowledge memory port. The access ends on an acknowledge, a bus error or an address error. Any transfer that arrives while the access is outstanding gets not-ready and its word is discarded. Read data, a completion status or an error status comes back on the transfers that follow.

Back-pressure rules: the transfer input has no ready signal. The block accepts a received word in every cycle, including while an access is outstanding, when the word is dropped. On the memory side, `mem_req` acts as valid and any of `mem_ack`, `mem_berr` or `mem_aerr` acts as ready. The request and all of its fields stay steady until one of those is sampled high. `busy` is a plain status output.

Top module: `dbg_cmd_responder`

## Requirements
- R1: After reset, `tx_word` is 0x0FFFF (status 0, data 0xFFFF), `busy` is 0 and `mem_req` is 0.
- R2: A command word is legal only when all of the following hold:
  - bits [15:8] equal 0x19;
  - bits 7 and [3:0] are zero;
  - the size field in bits [5:4] is not 11.

  Bit 6 selects read (1) or write (0). Size 00 is byte, 01 is word and 10 is long. An illegal command loads `tx_word` = 0x1FFFF, leaves `busy` low, starts no access, and the next word is again taken as a command.
- R3: A legal command raises `busy` and loads `tx_word` = 0x10000 (not-ready). Not-ready is also the response after each of the following words: address high half, address low half, and every write data word.
- R4: The address is {first word, second word}. A read starts the cycle after the low address word is received. A write first takes its data words and starts the cycle after the last one: one data word for byte and word, two for long (high first). Write data is zero-extended: byte uses bits [7:0] of its word, word uses all 16 bits, long is {high, low}. The request presents `mem_we`, `mem_size` (same code as R2), `mem_addr` and `mem_wdata`.
- R5: `mem_req` and its fields hold steady until `mem_ack`, `mem_berr` or `mem_aerr` is sampled high with it. `mem_req` is low in the following cycle.
- R6: While an access is outstanding, `tx_word` stays at not-ready and received words have no effect.
- R7: A successful long read loads {0, `mem_rdata`[31:16]} in the cycle after the acknowledge. The next transfer's word is ignored and loads {0, `mem_rdata`[15:0]}. The word received after that is a command.
- R8: A successful byte or word read loads a single result, {0, `mem_rdata` zero-filled above bit 7 or bit 15}. The next received word is a command.
- R9: A successful write loads the completion word 0x0FFFF, and the next received word is a command.
- R10: A bus error or an address error loads 0x10001 in place of any result or completion word, and the next received word is a command.
- R11: `busy` is high from the cycle after a legal command until the final response of that command is loaded, and `mem_req` is never high without `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a transfer completed |
| rx_word | input | 16 | Word received from the host on that transfer |
| tx_word | output | 17 | Status bit and word to send on the next transfer |
| busy | output | 1 | A command is in progress |
| mem_req | output | 1 | Memory access request (valid) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | 00 byte, 01 word, 10 long |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data, zero-extended |
| mem_rdata | input | 32 | Read data, sampled with the acknowledge |
| mem_ack | input | 1 | Access finished normally |
| mem_berr | input | 1 | Access finished with a bus error |
| mem_aerr | input | 1 | Access finished with an address error |

## Verification
The hardest case to reach is a host transfer that lands while a memory access is still open. Reaching it needs a legal command, a full address and, for writes, all data words, followed by a memory that holds back its acknowledge. The stimulus stalls the acknowledge for several cycles and sends a host word inside that window. It then checks two things: the response stays not-ready, and the dropped word has no effect on the later result. Error endings are driven after both read and write setups, and each one is followed immediately by a new command. This confirms that the transfer carrying the error status also delivers the next opcode.

// File: rtl/dbg_resp_pkg.sv
package dbg_resp_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA_HI,
    PH_DATA_LO,
    PH_ACCESS,
    PH_RES_LO
  } phase_e;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_resp_pkg::*;
#(
  parameter int               WORD_W = 16,
  parameter logic [OPC_W-1:0] OPCODE = 8'h19
) (
  input  logic [WORD_W-1:0] cmd_word,
  output logic              legal,
  output logic              is_read,
  output xfer_size_e        size
);

  localparam int RSV_HI = WORD_W - OPC_W - 1;

  logic opc_hit;
  logic rsv_clear;

  always_comb begin
    size      = xfer_size_e'(cmd_word[5:4]);
    is_read   = cmd_word[6];
    opc_hit   = (cmd_word[WORD_W-1 -: OPC_W] == OPCODE);
    rsv_clear = (cmd_word[RSV_HI:7] == '0) && (cmd_word[3:0] == 4'h0);
    legal     = opc_hit && rsv_clear && (size != SZ_BAD);
  end

endmodule

// File: rtl/dbg_mem_master.sv
module dbg_mem_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_we,
  input  logic [1:0]        launch_size,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic [DATA_W-1:0] launch_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_berr,
  input  logic              mem_aerr,
  output logic              done,
  output logic              fault
);

  assign done  = mem_req && (mem_ack || mem_berr || mem_aerr);
  assign fault = mem_req && (mem_berr || mem_aerr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= 2'b00;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (launch) begin
      mem_req   <= 1'b1;
      mem_we    <= launch_we;
      mem_size  <= launch_size;
      mem_addr  <= launch_addr;
      mem_wdata <= launch_wdata;
    end else if (done) begin
      mem_req <= 1'b0;
    end
  end

endmodule

// File: rtl/dbg_cmd_responder.sv
module dbg_cmd_responder
  import dbg_resp_pkg::*;
#(
  parameter int               WORD_W = 16,
  parameter logic [OPC_W-1:0] OPCODE = 8'h19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic [WORD_W-1:0]   rx_word,
  output logic [WORD_W:0]     tx_word,
  output logic                busy,
  output logic                mem_req,
  output logic                mem_we,
  output logic [1:0]          mem_size,
  output logic [2*WORD_W-1:0] mem_addr,
  output logic [2*WORD_W-1:0] mem_wdata,
  input  logic [2*WORD_W-1:0] mem_rdata,
  input  logic                mem_ack,
  input  logic                mem_berr,
  input  logic                mem_aerr
);

  localparam int LW = 2 * WORD_W;
  localparam int XW = WORD_W + 1;

  localparam logic [XW-1:0] RSP_NOT_READY = {1'b1, {WORD_W{1'b0}}};
  localparam logic [XW-1:0] RSP_ILLEGAL   = {1'b1, {WORD_W{1'b1}}};
  localparam logic [XW-1:0] RSP_FAULT     = {1'b1, WORD_W'(1)};
  localparam logic [XW-1:0] RSP_COMPLETE  = {1'b0, {WORD_W{1'b1}}};

  phase_e            phase;
  logic              cur_read;
  xfer_size_e        cur_size;
  logic [WORD_W-1:0] addr_hi;
  logic [WORD_W-1:0] addr_lo;
  logic [WORD_W-1:0] data_hi;
  logic [WORD_W-1:0] res_lo;
  logic [XW-1:0]     tx_q;

  logic              dec_legal;
  logic              dec_read;
  xfer_size_e        dec_size;

  logic              launch;
  logic [LW-1:0]     launch_addr;
  logic [LW-1:0]     launch_wdata;
  logic              acc_done;
  logic              acc_fault;
  logic [WORD_W-1:0] read_first;

  dbg_cmd_decode #(
    .WORD_W (WORD_W),
    .OPCODE (OPCODE)
  ) u_decode (
    .cmd_word (rx_word),
    .legal    (dec_legal),
    .is_read  (dec_read),
    .size     (dec_size)
  );

  // Launch on the word that completes the operand set.
  always_comb begin
    launch = rx_valid &&
             (((phase == PH_ADDR_LO) && cur_read) || (phase == PH_DATA_LO));
    launch_addr = (phase == PH_ADDR_LO) ? {addr_hi, rx_word} : {addr_hi, addr_lo};
    unique case (cur_size)
      SZ_BYTE: launch_wdata = {{(LW-8){1'b0}}, rx_word[7:0]};
      SZ_LONG: launch_wdata = {data_hi, rx_word};
      default: launch_wdata = {{WORD_W{1'b0}}, rx_word};
    endcase
  end

  dbg_mem_master #(
    .ADDR_W (LW),
    .DATA_W (LW)
  ) u_mem (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .launch_we    (!cur_read),
    .launch_size  (cur_size),
    .launch_addr  (launch_addr),
    .launch_wdata (launch_wdata),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_size     (mem_size),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_berr     (mem_berr),
    .mem_aerr     (mem_aerr),
    .done         (acc_done),
    .fault        (acc_fault)
  );

  // First (or only) result word of a read, zero-filled per size.
  always_comb begin
    unique case (cur_size)
      SZ_BYTE: read_first = {{(WORD_W-8){1'b0}}, mem_rdata[7:0]};
      SZ_LONG: read_first = mem_rdata[LW-1:WORD_W];
      default: read_first = mem_rdata[WORD_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      cur_read <= 1'b0;
      cur_size <= SZ_BYTE;
      addr_hi  <= '0;
      addr_lo  <= '0;
      data_hi  <= '0;
      res_lo   <= '0;
      tx_q     <= RSP_COMPLETE;
    end else begin
      unique case (phase)
        PH_CMD: if (rx_valid) begin
          if (dec_legal) begin
            cur_read <= dec_read;
            cur_size <= dec_size;
            tx_q     <= RSP_NOT_READY;
            phase    <= PH_ADDR_HI;
          end else begin
            tx_q <= RSP_ILLEGAL;
          end
        end
        PH_ADDR_HI: if (rx_valid) begin
          addr_hi <= rx_word;
          tx_q    <= RSP_NOT_READY;
          phase   <= PH_ADDR_LO;
        end
        PH_ADDR_LO: if (rx_valid) begin
          addr_lo <= rx_word;
          tx_q    <= RSP_NOT_READY;
          if (cur_read)                phase <= PH_ACCESS;
          else if (cur_size == SZ_LONG) phase <= PH_DATA_HI;
          else                         phase <= PH_DATA_LO;
        end
        PH_DATA_HI: if (rx_valid) begin
          data_hi <= rx_word;
          tx_q    <= RSP_NOT_READY;
          phase   <= PH_DATA_LO;
        end
        PH_DATA_LO: if (rx_valid) begin
          tx_q  <= RSP_NOT_READY;
          phase <= PH_ACCESS;
        end
        PH_ACCESS: if (acc_done) begin
          if (acc_fault) begin
            tx_q  <= RSP_FAULT;
            phase <= PH_CMD;
          end else if (!cur_read) begin
            tx_q  <= RSP_COMPLETE;
            phase <= PH_CMD;
          end else begin
            tx_q   <= {1'b0, read_first};
            res_lo <= mem_rdata[WORD_W-1:0];
            phase  <= (cur_size == SZ_LONG) ? PH_RES_LO : PH_CMD;
          end
        end
        PH_RES_LO: if (rx_valid) begin
          tx_q  <= {1'b0, res_lo};
          phase <= PH_CMD;
        end
        default: phase <= PH_CMD;
      endcase
    end
  end

  assign tx_word = tx_q;
  assign busy    = (phase != PH_CMD);

endmodule

// File: rtl/dbg_cmd_responder_chk.sv
module dbg_cmd_responder_chk #(
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [WORD_W:0]     tx_word,
  input logic                busy,
  input logic                mem_req,
  input logic                mem_we,
  input logic [1:0]          mem_size,
  input logic [2*WORD_W-1:0] mem_addr,
  input logic [2*WORD_W-1:0] mem_wdata,
  input logic                mem_ack,
  input logic                mem_berr,
  input logic                mem_aerr
);

  localparam logic [WORD_W:0] NOT_READY = {1'b1, {WORD_W{1'b0}}};
  localparam logic [WORD_W:0] ILLEGAL   = {1'b1, {WORD_W{1'b1}}};
  localparam logic [WORD_W:0] FAULT     = {1'b1, WORD_W'(1)};
  localparam logic [WORD_W:0] COMPLETE  = {1'b0, {WORD_W{1'b1}}};

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !(mem_ack || mem_berr || mem_aerr) |=>
      mem_req && $stable(mem_addr) && $stable(mem_we) &&
      $stable(mem_size) && $stable(mem_wdata));

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (mem_ack || mem_berr || mem_aerr) |=> !mem_req);

  a_r6_not_ready_while_open: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> tx_word == NOT_READY);

  a_r10_fault_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (mem_berr || mem_aerr) |=> tx_word == FAULT && !busy);

  a_r9_write_complete: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && !mem_berr && !mem_aerr |=> tx_word == COMPLETE);

  a_r11_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r2_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_word == ILLEGAL |-> !busy && !mem_req);

endmodule

bind dbg_cmd_responder dbg_cmd_responder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_word   (tx_word),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .mem_berr  (mem_berr),
  .mem_aerr  (mem_aerr)
);

// File: tb/dbg_cmd_responder_tb.sv
module dbg_cmd_responder_tb;

  localparam logic [16:0] NR   = 17'h10000;
  localparam logic [16:0] ILL  = 17'h1FFFF;
  localparam logic [16:0] FLT  = 17'h10001;
  localparam logic [16:0] CMPL = 17'h0FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [15:0] rx_word = '0;
  logic [16:0] tx_word;
  logic        busy;
  logic        mem_req, mem_we;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_berr = 1'b0, mem_aerr = 1'b0;

  always #2 clk = ~clk;

  dbg_cmd_responder u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
    .tx_word(tx_word), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_berr(mem_berr),
    .mem_aerr(mem_aerr)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    ended = 0;
  string cur_req = "R1";

  // Reference expectations, updated by the stimulus tasks.
  logic [16:0] exp_tx   = CMPL;
  logic        exp_busy = 1'b0;
  logic        exp_req  = 1'b0;
  logic        exp_we   = 1'b0;
  logic [1:0]  exp_size = '0;
  logic [31:0] exp_addr = '0, exp_wdata = '0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("tx_word", 64'(tx_word), 64'(exp_tx));
    chk("busy", 64'(busy), 64'(exp_busy));
    chk("mem_req", 64'(mem_req), 64'(exp_req));
    if (exp_req) begin
      chk("mem_we", 64'(mem_we), 64'(exp_we));
      chk("mem_size", 64'(mem_size), 64'(exp_size));
      chk("mem_addr", 64'(mem_addr), 64'(exp_addr));
      if (exp_we) chk("mem_wdata", 64'(mem_wdata), 64'(exp_wdata));
    end
  endtask

  // One host transfer, then one idle cycle.
  task automatic send(logic [15:0] w, logic [16:0] rsp, logic bsy, logic req);
    rx_valid = 1'b1;
    rx_word  = w;
    exp_tx   = rsp;
    exp_busy = bsy;
    exp_req  = req;
    tick();
    rx_valid = 1'b0;
    tick();
  endtask

  // Memory ends the access after lat cycles: kind 0 ack, 1 bus err, 2 addr err.
  task automatic finish_mem(int lat, int kind, logic [31:0] rd,
                            logic [16:0] rsp, logic bsy);
    for (int i = 1; i < lat; i++) tick();
    mem_rdata = rd;
    mem_ack   = (kind == 0);
    mem_berr  = (kind == 1);
    mem_aerr  = (kind == 2);
    exp_req   = 1'b0;
    exp_tx    = rsp;
    exp_busy  = bsy;
    tick();
    mem_ack  = 1'b0;
    mem_berr = 1'b0;
    mem_aerr = 1'b0;
  endtask

  function automatic logic [15:0] mk_cmd(bit rd, bit [1:0] sz);
    return {8'h19, 1'b0, rd, sz, 4'h0};
  endfunction

  task automatic setup_access(bit rd, bit [1:0] sz, logic [31:0] a, logic [31:0] wd);
    exp_we = !rd; exp_size = sz; exp_addr = a; exp_wdata = wd;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !ended) begin
      ended = 1;
      n_bad++;
      $display("FAIL %s watchdog actual=%0d expected=<20000", cur_req, cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    tick(); tick();

    cur_req = "R2";
    send(16'h1234, ILL, 0, 0);
    send(mk_cmd(1, 2'b11), ILL, 0, 0);
    send(16'h1958, ILL, 0, 0);       // reserved bit 3 set
    send(16'h19D0, ILL, 0, 0);       // reserved bit 7 set

    cur_req = "R3";
    send(mk_cmd(1, 2'b10), NR, 1, 0);
    send(16'h1234, NR, 1, 0);
    cur_req = "R4";
    setup_access(1, 2'b10, 32'h12345678, 32'h0);
    send(16'h5678, NR, 1, 1);
    cur_req = "R6";
    send(16'h1914, NR, 1, 1);        // word during access is dropped
    cur_req = "R5";
    finish_mem(4, 0, 32'hCAFEF00D, {1'b0, 16'hCAFE}, 1);
    cur_req = "R7";
    send(16'h1234, {1'b0, 16'hF00D}, 0, 0);

    cur_req = "R8";
    send(mk_cmd(1, 2'b01), NR, 1, 0);
    send(16'h00AB, NR, 1, 0);
    setup_access(1, 2'b01, 32'h00AB0010, 32'h0);
    send(16'h0010, NR, 1, 1);
    finish_mem(2, 0, 32'hAABBCCDD, {1'b0, 16'hCCDD}, 0);
    send(mk_cmd(1, 2'b00), NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    setup_access(1, 2'b00, 32'h00000003, 32'h0);
    send(16'h0003, NR, 1, 1);
    finish_mem(1, 0, 32'h11223344, {1'b0, 16'h0044}, 0);

    cur_req = "R9";
    send(mk_cmd(0, 2'b00), NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    send(16'h0101, NR, 1, 0);
    setup_access(0, 2'b00, 32'h00000101, 32'h000000A5);
    send(16'h12A5, NR, 1, 1);
    finish_mem(1, 0, 32'hFFFFFFFF, CMPL, 0);

    cur_req = "R4";
    send(mk_cmd(0, 2'b10), NR, 1, 0);
    send(16'h8000, NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    send(16'hDEAD, NR, 1, 0);
    setup_access(0, 2'b10, 32'h80000000, 32'hDEADBEEF);
    send(16'hBEEF, NR, 1, 1);
    cur_req = "R6";
    send(16'h0000, NR, 1, 1);
    send(16'hFFFF, NR, 1, 1);
    cur_req = "R9";
    finish_mem(3, 0, 32'h0, CMPL, 0);
    cur_req = "R4";
    send(mk_cmd(0, 2'b01), NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    send(16'h0040, NR, 1, 0);
    setup_access(0, 2'b01, 32'h00000040, 32'h00005A5A);
    send(16'h5A5A, NR, 1, 1);
    finish_mem(1, 0, 32'h0, CMPL, 0);

    cur_req = "R10";
    send(mk_cmd(1, 2'b10), NR, 1, 0);
    send(16'h0001, NR, 1, 0);
    setup_access(1, 2'b10, 32'h00010002, 32'h0);
    send(16'h0002, NR, 1, 1);
    finish_mem(2, 1, 32'h12345678, FLT, 0);
    send(mk_cmd(1, 2'b01), NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    setup_access(1, 2'b01, 32'h00000007, 32'h0);
    send(16'h0007, NR, 1, 1);
    finish_mem(1, 2, 32'h0000BEEF, FLT, 0);
    send(mk_cmd(0, 2'b01), NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    send(16'h0008, NR, 1, 0);
    setup_access(0, 2'b01, 32'h00000008, 32'h00001111);
    send(16'h1111, NR, 1, 1);
    finish_mem(2, 1, 32'h0, FLT, 0);

    cur_req = "R11";
    send(mk_cmd(1, 2'b10), NR, 1, 0);
    send(16'h0000, NR, 1, 0);
    setup_access(1, 2'b10, 32'h00000010, 32'h0);
    send(16'h0010, NR, 1, 1);
    finish_mem(1, 0, 32'h01020304, {1'b0, 16'h0102}, 1);
    send(mk_cmd(1, 2'b00), {1'b0, 16'h0304}, 0, 0);
    tick(); tick();

    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule